// File: doc/BRIEF.md
# Shared Power Domain Request Controller

This block controls a single switchable power domain that four independent agents may each ask to keep on: platform firmware, the operating-system driver, a remote-console agent and a debug agent. Each agent has its own word-wide request register on a simple memory-mapped write/read port. All four registers drive the same domain. The domain is powered while any one of them holds its request bit, and it may only power down once every request is clear.

A four-state sequencer handles the domain. Power-up holds the domain isolated for a fixed number of cycles after the enable output rises. Power-down raises isolation first and drops the enable output a fixed number of cycles later. A request that returns during power-down aborts it. Every register shows the same live "fully powered" status bit. A requester that sets its bit should poll that status before it uses the domain. Clearing a request needs no handshake.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, every request is clear, `dom_pwr_en` is 0, `dom_iso` is 1 and every register reads 0.
- R2: The four request registers sit at byte offsets 0x0, 0x4, 0x8 and 0xC, in the order firmware, driver, remote console, debug. An access decodes only when address bits [1:0] are 0 and the word index is below 4. Writes elsewhere change nothing, and reads there return 0.
- R3: Bit 31 of each register is a read/write request bit, and a write loads it from write-data bit 31 alone. Bit 30 is read-only status. Bits 29..0 read as 0, and write-data bits 30..0 have no effect.
- R4: Bit 30 reads 1 in all four registers exactly while the domain is fully on (`dom_pwr_en`=1 and `dom_iso`=0).
- R5: If a request bit is written to 1 at clock edge k while the domain is off, `dom_pwr_en` rises at edge k+1 with `dom_iso` still 1. `dom_iso` falls and the status rises at edge k+1+UP_CYCLES.
- R6: The domain stays fully on while at least one request bit is set. Clearing one requester's bit while another bit is still set has no effect on the outputs.
- R7: If the last request is cleared at edge k while the domain is on, `dom_iso` rises and the status falls at edge k+1, and `dom_pwr_en` falls at edge k+1+DN_CYCLES.
- R8: `dom_iso` is 1 whenever `dom_pwr_en` is 0.
- R9: If a request is set while the domain is powering down, the power-down is aborted before `dom_pwr_en` drops. A fresh power-up of UP_CYCLES cycles follows with `dom_iso` held at 1.
- R10: If every request is cleared during power-up, the power-up still completes to the fully-on state for one cycle, and then a normal power-down follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dom_pwr_en | output | 1 | Power-enable to the domain switches |
| dom_iso | output | 1 | Isolation clamp for the domain outputs |

## Verification
The combining logic is exercised with every one of the 15 non-empty sets of requesters. Their bits are then released one at a time, in ascending order. This separates a true OR of all four bits from logic that follows only the last write or a single register. Each requester also brings the domain up and down alone, with the full output timeline checked cycle by cycle. Further runs cover all-ones writes, misaligned and unmapped addresses, a request that arrives during power-down, a release during power-up, and a reset taken while the domain is on. These separate the abort path, the forced completion of power-up and the bit-masking rules from the plain on/off sequence.

// File: rtl/pdc_pkg.sv
// Package: shared definitions for the power domain request controller.
// Assumes: 32-bit register words; the request and status bit positions are
// fixed because software decodes them.
package pdc_pkg;
    localparam int REQ_BIT = 31;
    localparam int STS_BIT = 30;

    typedef enum logic [1:0] {
        PD_OFF  = 2'd0,
        PD_UP   = 2'd1,
        PD_ON   = 2'd2,
        PD_DOWN = 2'd3
    } pd_state_e;
endpackage

// File: rtl/pdc_regfile.sv
// Module: request register bank. Holds one request bit per requester,
// decodes word-aligned writes and builds the read word with the shared status.
// Assumes: NUM_REQ >= 2, ADDR_W > 2 + $clog2(NUM_REQ).
module pdc_regfile #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_bit,
    input  logic               dom_on,
    output logic [NUM_REQ-1:0] req_q,
    output logic [31:0]        rdata
);
    import pdc_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = $clog2(NUM_REQ);
    localparam logic [WORD_W-1:0] WORD_LIM = WORD_W'(NUM_REQ);

    logic [WORD_W-1:0] word;
    logic              hit;
    logic [IDX_W-1:0]  sel;

    // Decode: aligned access to an implemented word.
    always_comb begin
        word = addr[ADDR_W-1:2];
        hit  = (addr[1:0] == 2'b00) && (word < WORD_LIM);
        sel  = word[IDX_W-1:0];
    end

    // One request flop per requester.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        // Load the request bit on a decoded write to this word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                req_q[i] <= 1'b0;
            else if (wr_en && hit && (sel == IDX_W'(i)))
                req_q[i] <= wr_bit;
        end
    end

    // Read mux: own request bit plus the shared status; the rest reads 0.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[REQ_BIT] = req_q[sel];
            rdata[STS_BIT] = dom_on;
        end
    end
endmodule

// File: rtl/pdc_delay_timer.sv
// Module: delay counter for the sequencer. Counts up from zero after a clear
// and flags done when the count reaches the given last value, then holds.
// Assumes: lim_last is stable while counting.
module pdc_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim_last,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Terminal compare.
    assign done = (cnt_q == lim_last);

    // Count and saturate at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pdc_sequencer.sv
// Module: power-up / power-down sequencer for the single domain.
// Power-up holds isolation for UP_CYCLES cycles. Power-down raises isolation
// and keeps power for DN_CYCLES cycles. A request during power-down aborts it.
// Assumes: UP_CYCLES >= 1, DN_CYCLES >= 1.
module pdc_sequencer #(
    parameter int UP_CYCLES = 1000,
    parameter int DN_CYCLES = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_req,
    output pdc_pkg::pd_state_e state_q,
    output logic               pwr_en,
    output logic               iso,
    output logic               dom_on
);
    import pdc_pkg::*;

    localparam int MAX_CYC = (UP_CYCLES > DN_CYCLES) ? UP_CYCLES : DN_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_CYCLES - 1);
    localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DN_CYCLES - 1);

    pd_state_e        state_d;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_last;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_OFF:  if (any_req)  state_d = PD_UP;
            PD_UP:   if (tmr_done) state_d = PD_ON;
            PD_ON:   if (!any_req) state_d = PD_DOWN;
            PD_DOWN: begin
                if (any_req)       state_d = PD_UP;
                else if (tmr_done) state_d = PD_OFF;
            end
            default:               state_d = PD_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PD_OFF;
        else
            state_q <= state_d;
    end

    // Delay limit for the current transition state.
    assign tmr_last = (state_q == PD_UP) ? UP_LAST : DN_LAST;

    pdc_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_d != state_q),
        .lim_last (tmr_last),
        .done     (tmr_done)
    );

    // Output decode from state.
    always_comb begin
        pwr_en = (state_q != PD_OFF);
        iso    = (state_q != PD_ON);
        dom_on = (state_q == PD_ON);
    end
endmodule

// File: rtl/pwr_domain_ctrl.sv
// Module: top of the shared power domain controller. Combines the requester
// registers into one request and drives the domain sequencer.
// Assumes: single clock, synchronous active-low reset.
module pwr_domain_ctrl #(
    parameter int NUM_REQ   = 4,
    parameter int ADDR_W    = 8,
    parameter int UP_CYCLES = 1000,
    parameter int DN_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dom_pwr_en,
    output logic              dom_iso
);
    import pdc_pkg::*;

    logic [NUM_REQ-1:0] req_q;
    logic               dom_on;
    pd_state_e          state_q;

    pdc_regfile #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wr_bit (reg_wdata[REQ_BIT]),
        .dom_on (dom_on),
        .req_q  (req_q),
        .rdata  (reg_rdata)
    );

    pdc_sequencer #(.UP_CYCLES(UP_CYCLES), .DN_CYCLES(DN_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (|req_q),
        .state_q (state_q),
        .pwr_en  (dom_pwr_en),
        .iso     (dom_iso),
        .dom_on  (dom_on)
    );
endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
// Module: property checker bound to the controller top.
// Assumes: it is attached by the bind below and sees the request flops and state.
module pwr_domain_ctrl_chk #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               dom_pwr_en,
    input logic               dom_iso,
    input logic [NUM_REQ-1:0] req_q,
    input pdc_pkg::pd_state_e state_q
);
    import pdc_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = $clog2(NUM_REQ);
    localparam logic [WORD_W-1:0] WORD_LIM = WORD_W'(NUM_REQ);

    logic             acc_hit;
    logic [IDX_W-1:0] acc_idx;

    // Independent decode of the accessed word.
    always_comb begin
        acc_hit = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:2] < WORD_LIM);
        acc_idx = reg_addr[2 +: IDX_W];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (req_q == '0) && !dom_pwr_en && dom_iso);

    // R2
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && acc_hit) |=> (req_q[$past(acc_idx)] == $past(reg_wdata[REQ_BIT])));

    // R3
    low_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && acc_hit && (reg_wdata[STS_BIT:0] != '0) && !reg_wdata[REQ_BIT])
        |=> !req_q[$past(acc_idx)]);

    // R4
    status_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> (reg_rdata[STS_BIT] == (dom_pwr_en && !dom_iso)));

    // R5
    power_up_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_OFF && (req_q != '0)) |=> (dom_pwr_en && dom_iso));

    // R6
    hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_ON && (req_q != '0)) |=> (dom_pwr_en && !dom_iso));

    // R7
    iso_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_ON && (req_q == '0)) |=> (dom_pwr_en && dom_iso));

    // R8
    iso_when_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_pwr_en |-> dom_iso);

    // R9
    abort_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_DOWN && (req_q != '0)) |=> (state_q == PD_UP && dom_pwr_en));

    // R10
    up_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_UP) |=> (dom_pwr_en));
endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .dom_pwr_en (dom_pwr_en),
    .dom_iso    (dom_iso),
    .req_q      (req_q),
    .state_q    (state_q)
);

// File: tb/pwr_domain_ctrl_test.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_test;
    localparam int UP = 5;
    localparam int DN = 3;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr_en;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          dom_pwr_en;
    logic          dom_iso;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_domain_ctrl #(.NUM_REQ(4), .ADDR_W(AW), .UP_CYCLES(UP), .DN_CYCLES(DN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dom_pwr_en(dom_pwr_en), .dom_iso(dom_iso)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // Expected word: request bit at 31, shared status at 30.
    task automatic check_regs(input string req, input logic [3:0] mask, input logic on);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(AW'(i * 4), d);
            chk(req, $sformatf("reg%0d", i), d, {mask[i], on, 30'b0});
        end
    endtask

    task automatic up_seq(input string req, input logic pwr_before, input logic [3:0] mask);
        chk(req, "pwr before", {31'b0, dom_pwr_en}, {31'b0, pwr_before});
        step(1);
        chk(req, "pwr first", {31'b0, dom_pwr_en}, 32'd1);
        chk(req, "iso first", {31'b0, dom_iso}, 32'd1);
        check_regs(req, mask, 1'b0);
        step(UP - 1);
        chk(req, "iso last up", {31'b0, dom_iso}, 32'd1);
        step(1);
        chk(req, "iso on", {31'b0, dom_iso}, 32'd0);
        chk(req, "pwr on", {31'b0, dom_pwr_en}, 32'd1);
        check_regs(req, mask, 1'b1);
    endtask

    task automatic down_seq(input string req);
        chk(req, "iso still on", {31'b0, dom_iso}, 32'd0);
        step(1);
        chk(req, "iso down", {31'b0, dom_iso}, 32'd1);
        chk(req, "pwr down", {31'b0, dom_pwr_en}, 32'd1);
        check_regs(req, 4'b0000, 1'b0);
        step(DN - 1);
        chk(req, "pwr last down", {31'b0, dom_pwr_en}, 32'd1);
        step(1);
        chk(req, "pwr off", {31'b0, dom_pwr_en}, 32'd0);
        chk(req, "iso off", {31'b0, dom_iso}, 32'd1);
    endtask

    // R8: isolation whenever unpowered, sampled every cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished)
            chk("R8", "iso while unpowered", {31'b0, (!dom_pwr_en && !dom_iso)}, 32'd0);
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  cur;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        step(3);
        // R1: in reset
        chk("R1", "pwr in reset", {31'b0, dom_pwr_en}, 32'd0);
        chk("R1", "iso in reset", {31'b0, dom_iso}, 32'd1);
        check_regs("R1", 4'b0000, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "pwr after reset", {31'b0, dom_pwr_en}, 32'd0);
        check_regs("R1", 4'b0000, 1'b0);

        // R5 / R7: each requester alone
        for (int i = 0; i < 4; i++) begin
            wr(AW'(i * 4), 32'h8000_0000);
            up_seq("R5", 1'b0, 4'(1 << i));
            wr(AW'(i * 4), 32'h0);
            down_seq("R7");
            step(2);
        end

        // R6: every non-empty requester set, released one bit at a time
        for (int m = 1; m < 16; m++) begin
            for (int b = 0; b < 4; b++)
                if (m[b]) wr(AW'(b * 4), 32'h8000_0000);
            step(UP + 2);
            check_regs("R6", 4'(m), 1'b1);
            cur = 4'(m);
            for (int b = 0; b < 4; b++) begin
                if (cur[b]) begin
                    cur[b] = 1'b0;
                    wr(AW'(b * 4), 32'h0);
                    if (cur != 4'b0) begin
                        step(2);
                        chk("R6", "still on iso", {31'b0, dom_iso}, 32'd0);
                        chk("R6", "still on pwr", {31'b0, dom_pwr_en}, 32'd1);
                        check_regs("R6", cur, 1'b1);
                    end else begin
                        down_seq("R6");
                    end
                end
            end
            step(1);
        end

        // R3: all-ones write and bit-31-clear write with other bits set
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d);
        chk("R3", "all ones while off", d, 32'h8000_0000);
        up_seq("R3", 1'b0, 4'b0010);
        wr(8'h04, 32'h7FFF_FFFF);
        rd(8'h04, d);
        chk("R3", "clear with low bits", d, 32'h4000_0000);
        down_seq("R3");
        step(2);

        // R2: misaligned and unmapped writes do nothing
        wr(8'h05, 32'h8000_0000);
        wr(8'h10, 32'h8000_0000);
        wr(8'hFC, 32'h8000_0000);
        step(2);
        chk("R2", "pwr after stray writes", {31'b0, dom_pwr_en}, 32'd0);
        rd(8'h05, d); chk("R2", "misaligned read", d, 32'h0);
        rd(8'h10, d); chk("R2", "unmapped read", d, 32'h0);
        check_regs("R2", 4'b0000, 1'b0);

        // R9: request returns during power-down
        wr(8'h0C, 32'h8000_0000);
        up_seq("R9", 1'b0, 4'b1000);
        wr(8'h0C, 32'h0);
        step(1);
        chk("R9", "in power-down iso", {31'b0, dom_iso}, 32'd1);
        wr(8'h00, 32'h8000_0000);
        up_seq("R9", 1'b1, 4'b0001);
        wr(8'h00, 32'h0);
        down_seq("R9");
        step(2);

        // R10: release during power-up
        wr(8'h08, 32'h8000_0000);
        step(1);
        wr(8'h08, 32'h0);
        step(UP - 2);
        chk("R10", "still up iso", {31'b0, dom_iso}, 32'd1);
        step(1);
        chk("R10", "reaches on", {31'b0, dom_iso}, 32'd0);
        check_regs("R10", 4'b0000, 1'b1);
        step(1);
        chk("R10", "then down iso", {31'b0, dom_iso}, 32'd1);
        chk("R10", "then down pwr", {31'b0, dom_pwr_en}, 32'd1);
        step(DN);
        chk("R10", "off", {31'b0, dom_pwr_en}, 32'd0);
        step(2);

        // R1: reset taken while on
        wr(8'h04, 32'h8000_0000);
        step(UP + 2);
        chk("R1", "on before reset", {31'b0, dom_iso}, 32'd0);
        rst_n = 1'b0;
        step(1);
        chk("R1", "pwr reset while on", {31'b0, dom_pwr_en}, 32'd0);
        chk("R1", "iso reset while on", {31'b0, dom_iso}, 32'd1);
        check_regs("R1", 4'b0000, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1", "stays off", {31'b0, dom_pwr_en}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule